// File: doc/BRIEF.md
# Block-Addressed Non-Volatile Store Responder

This block answers the commands that a command-frame processor sends to one fixed channel, behind which sits a small non-volatile store organised in 8-byte blocks. The frame processor hands over one command at a time: the channel index, the command byte, the transmit and receive lengths, and up to nine operand bytes. Some cycles later the block returns one response. The response is either a set of bytes or an error flag.

Three command families are served. An identify command reports a capacity code. A block read returns the eight bytes of the addressed block. A block write stores eight bytes into the addressed block. Everything else on the channel is refused. This includes the clock-chip commands that share the channel, malformed lengths, block numbers past the end of the array, and any command that arrives for a different channel. The storage array sits inside the block, and its size is a parameter (512 or 2048 bytes).

The controlling state machine has four states:

- `ST_IDLE` waits for a command and captures it.
- `ST_DECODE` classifies the captured command.
- `ST_ACCESS` performs the single array read or write.
- `ST_REPLY` presents the response for one cycle.

The transitions are:

- IDLE→DECODE on an accepted command.
- DECODE→ACCESS for a valid read or write.
- DECODE→REPLY for an identify or a refusal.
- ACCESS→REPLY always.
- REPLY→IDLE always.

Top module: `eep_responder`

## Requirements
- R1: `cmd_ready` is high only in the idle state. It goes low on the clock edge that accepts a command (`cmd_valid` and `cmd_ready` both high) and stays low until the cycle after the response. `rsp_valid` is high for exactly one cycle per accepted command.
- R2: Identify commands and refused commands produce `rsp_valid` two cycles after the accepting edge. Successful reads and writes produce it three cycles after.
- R3: A command whose `cmd_chan` differs from parameter `CHAN_ID` (default 4) is answered with `rsp_err`=1.
- R4: Command codes 0x00 and 0xFF identify the store. The response has byte 0 = 0x00, byte 1 = 0xC0 when `CAP_BYTES` is 2048 (0x80 otherwise), byte 2 = 0x00, and all other bytes zero. Response byte i is `rsp_data[8*i+7:8*i]`.
- R5: Code 0x04 with transmit length 2 and receive length 8 reads block `cmd_payload[7:0]`. Byte i of the block is returned in response byte i, with `rsp_err`=0.
- R6: Code 0x05 with transmit length 10 writes `cmd_payload[71:8]` into block `cmd_payload[7:0]`, with payload byte i+1 becoming block byte i. The response has `rsp_err`=0 and zero data.
- R7: A read or write is refused with `rsp_err`=1 when the block number times 8 exceeds `CAP_BYTES`-8, or when `HAS_STORE` is 0. A refused write leaves the array unchanged.
- R8: A read whose lengths are not 2/8, or a write whose transmit length is not 10, is refused with `rsp_err`=1 and changes nothing.
- R9: Codes 0x06, 0x07 and 0x08 are refused with `rsp_err`=1, as is every code other than 0x00, 0x04, 0x05 and 0xFF.
- R10: While `rsp_valid` is high with `rsp_err`=1, `rsp_data` is zero.
- R11: The array update of a write takes effect before its response cycle. A read issued right after the write's response returns the new bytes.
- R12: After reset the state is idle (`cmd_ready`=1, `rsp_valid`=0) and every block reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_chan | input | CHW | Channel index of the command |
| cmd_code | input | 8 | Command byte |
| cmd_tx_len | input | 8 | Transmit length in bytes, command byte included |
| cmd_rx_len | input | 8 | Receive length in bytes |
| cmd_payload | input | 72 | Operand bytes following the command byte; byte j at [8*j+7:8*j] |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_err | output | 1 | Command refused |
| rsp_data | output | 64 | Response bytes; byte i at [8*i+7:8*i] |

## Verification
Several properties are checked on every cycle:

- `cmd_ready` is low during the response, and the response lasts one cycle.
- Refusals carry zero data.
- Foreign-channel and clock-chip commands end in an error exactly two cycles after acceptance.
- Every array write is followed at once by a successful response.

Only the bench's scenarios can show certain behaviours. These are the content of reads after writes, the last valid block versus the first invalid one, the capacity code for both sizes, and the untouched array after a refused write. The bench shows these by comparing against a behavioural byte-array model on every clock.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ACCESS,
        ST_REPLY
    } eep_state_e;

    typedef enum logic [1:0] {
        K_STATUS,
        K_READ,
        K_WRITE,
        K_REFUSE
    } eep_kind_e;

    localparam logic [7:0] OP_IDENT  = 8'h00;
    localparam logic [7:0] OP_IDENT2 = 8'hFF;
    localparam logic [7:0] OP_RDBLK  = 8'h04;
    localparam logic [7:0] OP_WRBLK  = 8'h05;
endpackage

// File: rtl/eep_decode.sv
module eep_decode
    import eep_pkg::*;
#(
    parameter int CHW       = 3,
    parameter int CHAN_ID   = 4,
    parameter int BLOCKS    = 64,
    parameter int HAS_STORE = 1
) (
    input  logic [CHW-1:0] chan,
    input  logic [7:0]     code,
    input  logic [7:0]     tx_len,
    input  logic [7:0]     rx_len,
    input  logic [7:0]     blk,
    output eep_kind_e      kind
);
    logic in_range;
    logic stored;

    assign in_range = ({24'd0, blk} < 32'(BLOCKS));
    assign stored   = (HAS_STORE != 0);

    always_comb begin
        kind = K_REFUSE;
        if (chan == CHW'(CHAN_ID)) begin
            unique case (code)
                OP_IDENT, OP_IDENT2: kind = K_STATUS;
                OP_RDBLK: kind = (stored && in_range && tx_len == 8'd2 && rx_len == 8'd8)
                                 ? K_READ : K_REFUSE;
                OP_WRBLK: kind = (stored && in_range && tx_len == 8'd10)
                                 ? K_WRITE : K_REFUSE;
                default:  kind = K_REFUSE;
            endcase
        end
    end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int BLOCKS = 64,
    localparam int ABW   = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic           re,
    input  logic [ABW-1:0] addr,
    input  logic [63:0]    wdata,
    output logic [63:0]    rdata
);
    logic [63:0] mem [BLOCKS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BLOCKS; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (we) mem[addr] <= wdata;
            if (re) rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/eep_responder.sv
module eep_responder
    import eep_pkg::*;
#(
    parameter int CAP_BYTES = 512,
    parameter int HAS_STORE = 1,
    parameter int CHAN_ID   = 4,
    parameter int CHW       = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    output logic           cmd_ready,
    input  logic [CHW-1:0] cmd_chan,
    input  logic [7:0]     cmd_code,
    input  logic [7:0]     cmd_tx_len,
    input  logic [7:0]     cmd_rx_len,
    input  logic [71:0]    cmd_payload,
    output logic           rsp_valid,
    output logic           rsp_err,
    output logic [63:0]    rsp_data
);
    localparam int BLOCKS = CAP_BYTES / 8;
    localparam int ABW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
    localparam logic [7:0] ID_CODE = (CAP_BYTES == 2048) ? 8'hC0 : 8'h80;

    eep_state_e     state_q, state_d;
    eep_kind_e      kind_q, kind_d;
    logic [CHW-1:0] chan_q;
    logic [7:0]     code_q, tx_q, rx_q, blk_q;
    logic [63:0]    wdata_q;
    logic [63:0]    rdata;
    logic           store_we, store_re;

    eep_decode #(
        .CHW(CHW), .CHAN_ID(CHAN_ID), .BLOCKS(BLOCKS), .HAS_STORE(HAS_STORE)
    ) u_dec (
        .chan(chan_q), .code(code_q), .tx_len(tx_q), .rx_len(rx_q),
        .blk(blk_q), .kind(kind_d)
    );

    assign store_we = (state_q == ST_ACCESS) && (kind_q == K_WRITE);
    assign store_re = (state_q == ST_ACCESS) && (kind_q == K_READ);

    eep_store #(.BLOCKS(BLOCKS)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(store_we), .re(store_re),
        .addr(blk_q[ABW-1:0]), .wdata(wdata_q), .rdata(rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid) state_d = ST_DECODE;
            ST_DECODE: state_d = (kind_d == K_READ || kind_d == K_WRITE) ? ST_ACCESS : ST_REPLY;
            ST_ACCESS: state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // command capture and classification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q  <= '0;
            code_q  <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            blk_q   <= '0;
            wdata_q <= '0;
            kind_q  <= K_REFUSE;
        end else begin
            if (state_q == ST_IDLE && cmd_valid) begin
                chan_q  <= cmd_chan;
                code_q  <= cmd_code;
                tx_q    <= cmd_tx_len;
                rx_q    <= cmd_rx_len;
                blk_q   <= cmd_payload[7:0];
                wdata_q <= cmd_payload[71:8];
            end
            if (state_q == ST_DECODE) kind_q <= kind_d;
        end
    end

    // outputs
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_REPLY);
        rsp_err   = 1'b0;
        rsp_data  = '0;
        if (state_q == ST_REPLY) begin
            unique case (kind_q)
                K_STATUS: rsp_data = {48'd0, ID_CODE, 8'h00};
                K_READ:   rsp_data = rdata;
                K_WRITE:  rsp_data = '0;
                K_REFUSE: rsp_err  = 1'b1;
                default:  rsp_err  = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/eep_responder_chk.sv
module eep_responder_chk #(
    parameter int CHAN_ID = 4,
    parameter int CHW     = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_valid,
    input logic           cmd_ready,
    input logic [CHW-1:0] cmd_chan,
    input logic [7:0]     cmd_code,
    input logic           rsp_valid,
    input logic           rsp_err,
    input logic [63:0]    rsp_data,
    input logic           store_we
);
    logic accept;
    assign accept = cmd_valid && cmd_ready;

    AST_REPLY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready); // R1
    AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R1
    AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!rsp_valid && !cmd_ready)); // R2
    AST_FOREIGN_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_chan != CHW'(CHAN_ID)) |=> ##1 (rsp_valid && rsp_err)); // R3
    AST_CLOCKCHIP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_code >= 8'h06 && cmd_code <= 8'h08) |=> ##1 (rsp_valid && rsp_err)); // R9
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_data == 64'd0)); // R10
    AST_COMMIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |=> (rsp_valid && !rsp_err)); // R11
endmodule

bind eep_responder eep_responder_chk #(.CHAN_ID(CHAN_ID), .CHW(CHW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chan(cmd_chan), .cmd_code(cmd_code), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .store_we(store_we)
);

// File: tb/sim_eep_responder.sv
module sim_eep_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_chan = '0;
    logic [7:0]  cmd_code = '0, cmd_tx_len = '0, cmd_rx_len = '0;
    logic [71:0] cmd_payload = '0;
    logic        rdy0, val0, err0, rdy1, val1, err1;
    logic [63:0] dat0, dat1;

    int checks = 0;
    int fails  = 0;
    logic [63:0] model0 [64];

    always #10 clk = ~clk;

    eep_responder u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy0),
        .cmd_chan(cmd_chan), .cmd_code(cmd_code), .cmd_tx_len(cmd_tx_len),
        .cmd_rx_len(cmd_rx_len), .cmd_payload(cmd_payload),
        .rsp_valid(val0), .rsp_err(err0), .rsp_data(dat0)
    );

    eep_responder #(.CAP_BYTES(2048), .HAS_STORE(0)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy1),
        .cmd_chan(cmd_chan), .cmd_code(cmd_code), .cmd_tx_len(cmd_tx_len),
        .cmd_rx_len(cmd_rx_len), .cmd_payload(cmd_payload),
        .rsp_valid(val1), .rsp_err(err1), .rsp_data(dat1)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic predict(input int cap, input bit pres, input logic [2:0] ch,
                           input logic [7:0] code, tx, rx, blk,
                           output bit err, output logic [63:0] data,
                           output int lat, output bit wr);
        bit ok_blk;
        ok_blk = pres && (int'(blk) * 8 <= cap - 8);
        err = 1'b1; data = '0; lat = 2; wr = 1'b0;
        if (ch == 3'd4) begin
            if (code == 8'h00 || code == 8'hFF) begin
                err = 1'b0;
                data = (cap == 2048) ? 64'h0000_0000_0000_C000 : 64'h0000_0000_0000_8000;
            end else if (code == 8'h04 && tx == 8'd2 && rx == 8'd8 && ok_blk) begin
                err = 1'b0; lat = 3;
                data = (cap == 512) ? model0[blk[5:0]] : 64'd0;
            end else if (code == 8'h05 && tx == 8'd10 && ok_blk) begin
                err = 1'b0; lat = 3; wr = 1'b1;
            end
        end
    endtask

    task automatic run(input string req, input logic [2:0] ch, input logic [7:0] code,
                       input logic [7:0] tx, input logic [7:0] rx, input logic [7:0] blk,
                       input logic [63:0] wd);
        bit e0, e1, w0, w1;
        logic [63:0] d0, d1;
        int l0, l1;
        predict(512, 1'b1, ch, code, tx, rx, blk, e0, d0, l0, w0);
        predict(2048, 1'b0, ch, code, tx, rx, blk, e1, d1, l1, w1);
        cmd_chan = ch; cmd_code = code; cmd_tx_len = tx; cmd_rx_len = rx;
        cmd_payload = {wd, blk}; cmd_valid = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (i == 1) cmd_valid = 1'b0;
            chk(rdy0 == (i > l0), "R1", "u0 ready", 64'(rdy0), 64'(i > l0));
            chk(val0 == (i == l0), "R2", "u0 valid", 64'(val0), 64'(i == l0));
            chk(rdy1 == (i > l1), "R1", "u1 ready", 64'(rdy1), 64'(i > l1));
            chk(val1 == (i == l1), "R2", "u1 valid", 64'(val1), 64'(i == l1));
            if (i == l0) begin
                chk(err0 == e0, req, "u0 err", 64'(err0), 64'(e0));
                chk(dat0 == d0, req, "u0 data", dat0, d0);
            end
            if (i == l1) begin
                chk(err1 == e1, req, "u1 err", 64'(err1), 64'(e1));
                chk(dat1 == d1, req, "u1 data", dat1, d1);
            end
        end
        if (w0) model0[blk[5:0]] = wd;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model0[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy0 == 1'b1 && val0 == 1'b0, "R12", "reset idle", {rdy0, val0}, 2'b10);
        run("R12", 3'd4, 8'h04, 8'd2, 8'd8, 8'd0, '0);
        run("R4",  3'd4, 8'h00, 8'd1, 8'd3, 8'd0, '0);
        run("R4",  3'd4, 8'hFF, 8'd1, 8'd3, 8'd0, '0);
        run("R6",  3'd4, 8'h05, 8'd10, 8'd0, 8'd3, 64'h8877_6655_4433_2211);
        run("R11", 3'd4, 8'h04, 8'd2, 8'd8, 8'd3, '0);
        run("R6",  3'd4, 8'h05, 8'd10, 8'd0, 8'd63, 64'hDEAD_BEEF_0123_4567);
        run("R5",  3'd4, 8'h04, 8'd2, 8'd8, 8'd63, '0);
        run("R7",  3'd4, 8'h05, 8'd10, 8'd0, 8'd64, 64'hFFFF_FFFF_FFFF_FFFF);
        run("R7",  3'd4, 8'h04, 8'd2, 8'd8, 8'd64, '0);
        run("R7",  3'd4, 8'h04, 8'd2, 8'd8, 8'd255, '0);
        run("R7",  3'd4, 8'h04, 8'd2, 8'd8, 8'd0, '0);
        run("R8",  3'd4, 8'h05, 8'd9, 8'd0, 8'd3, 64'h0101_0101_0101_0101);
        run("R8",  3'd4, 8'h04, 8'd3, 8'd8, 8'd3, '0);
        run("R8",  3'd4, 8'h04, 8'd2, 8'd4, 8'd3, '0);
        run("R5",  3'd4, 8'h04, 8'd2, 8'd8, 8'd3, '0);
        run("R3",  3'd2, 8'h00, 8'd1, 8'd3, 8'd0, '0);
        run("R3",  3'd0, 8'h05, 8'd10, 8'd0, 8'd5, 64'h5555_5555_5555_5555);
        run("R3",  3'd4, 8'h04, 8'd2, 8'd8, 8'd5, '0);
        run("R9",  3'd4, 8'h06, 8'd1, 8'd3, 8'd0, '0);
        run("R9",  3'd4, 8'h07, 8'd2, 8'd9, 8'd0, '0);
        run("R9",  3'd4, 8'h08, 8'd10, 8'd1, 8'd0, '0);
        run("R9",  3'd4, 8'h01, 8'd1, 8'd4, 8'd0, '0);
        run("R10", 3'd4, 8'h33, 8'd1, 8'd1, 8'd0, '0);
        for (int k = 0; k < 16; k++) begin
            run("R6", 3'd4, 8'h05, 8'd10, 8'd0, 8'((k * 37) % 64),
                {32'(k * 32'h1234_5679), 32'(~k)});
            run("R5", 3'd4, 8'h04, 8'd2, 8'd8, 8'((k * 11) % 64), '0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule